// File: doc/BRIEF.md
# USB Receive Packet Checker

This block sits behind a byte-wide receive interface of the kind a USB transceiver macro presents: a data byte, a per-byte valid strobe, a line-active envelope and an error flag. It treats each period of the active envelope as one packet. It keeps the first byte as the packet identifier, counts the bytes and runs a CRC16 over everything after the identifier. When the envelope drops it returns a verdict for the packet.

The verdict is a one-cycle pulse that carries the 4-bit identifier, the identifier integrity flag, the payload length, the CRC flag and a few class flags: single-byte handshake, acknowledge, too short to be a data packet, and an overall bad flag. For data packets the payload is streamed out as it arrives. Two bytes are always held back in a small delay line, so the two trailing CRC bytes never reach the payload stream and no packet-sized buffer is needed.

Top module: `usb_rx_pkt_chk`

## Requirements
- R1: A byte is taken into the packet only in a cycle where rx_valid and rx_active are both high. A byte offered with rx_valid high while rx_active is low does not change the count, the identifier or the CRC.
- R2: done is high for exactly one cycle, in the cycle after the clock edge that first samples rx_active low following a cycle with it high. All verdict outputs keep their values until the next done.
- R3: pid_ok is 1 when the first byte's upper nibble is the bitwise inverse of its lower nibble. pkt_pid is the lower nibble. A packet with no bytes reports pkt_pid 0 and pid_ok 0.
- R4: A packet is a data packet when bits [1:0] of the identifier are 2'b11. For a data packet of N >= 3 bytes, pkt_len is N-3. For every other packet it is 0.
- R5: crc_ok is 1 for a data packet of at least 3 bytes when the last two bytes are the CRC16 of the bytes between them and the identifier. That CRC uses initial value 0xFFFF and polynomial x^16+x^15+x^2+1, takes each byte LSB first, and is sent inverted, bit-reflected, low byte first.
- R6: For a data packet, the bytes after the identifier, without the last two, appear on pl_data in arrival order, each with a one-cycle pl_valid. The two trailing bytes never appear.
- R7: A packet of exactly one byte sets pkt_hshk. pkt_ack is set only when that byte is 0xD2.
- R8: If rx_error is high in any cycle in which rx_active is high, the packet reports pkt_bad.
- R9: A data packet with fewer than 3 bytes sets pkt_short, with pkt_len 0 and crc_ok 0.
- R10: After reset, done, pl_valid and all verdict outputs are 0.
- R11: A packet whose identifier is not a data identifier produces no pl_valid, and reports crc_ok 0 and pkt_len 0.
- R12: pkt_bad is the OR of a seen error, pid_ok low, pkt_short, and a data packet with crc_ok low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | rx_data holds a byte this cycle |
| rx_active | input | 1 | Packet envelope |
| rx_error | input | 1 | Receive error indication |
| pl_data | output | 8 | Forwarded payload byte |
| pl_valid | output | 1 | pl_data valid strobe |
| done | output | 1 | One-cycle end-of-packet pulse |
| pkt_pid | output | 4 | Identifier lower nibble |
| pkt_len | output | 11 | Payload byte count |
| pid_ok | output | 1 | Identifier nibble check passed |
| crc_ok | output | 1 | Data CRC check passed |
| pkt_hshk | output | 1 | Single-byte packet |
| pkt_ack | output | 1 | Single byte equal to 0xD2 |
| pkt_short | output | 1 | Data packet under 3 bytes |
| pkt_bad | output | 1 | Packet failed any check |

## Verification
The bench inserts idle gaps between valid bytes. A design that counted cycles instead of strobes would then report the wrong lengths and CRC results. It drives a junk byte with rx_valid high in the very cycle rx_active drops: a checker that ignored the envelope would add it to the length and break the CRC. It covers empty, one-byte and two-byte data packets and a zero-payload data packet, where an off-by-one in the hold line would leak a CRC byte or drop payload. It also sends data packets with one corrupted byte and packets with a single error cycle, which a design that missed either would report as good.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int          BYTE_W      = 8;
  localparam int          CRC_W       = 16;
  localparam int          CRC_BYTES   = CRC_W / BYTE_W;
  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RF = 16'hA001;  // reflected 0x8005
  localparam logic [15:0] CRC_GOOD    = 16'hB001;  // residue over data+crc
  localparam logic [7:0]  ACK_CODE    = 8'hD2;

  // one byte, LSB first, through the reflected CRC16 register
  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                             input logic [7:0]  d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_RF;
    end
    return c;
  endfunction

  function automatic logic pid_is_data(input logic [3:0] p);
    return p[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/rxpk_crc.sv
module rxpk_crc
  import rxpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] base;

  assign base = clr ? CRC_SEED : crc_q;

  always_ff @(posedge clk) begin
    if (rst)     crc_q <= CRC_SEED;
    else if (en) crc_q <= crc16_byte(base, din);
    else         crc_q <= base;
  end

  // R5
  crc_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !en) |=> (crc_q == CRC_SEED));
  // R1
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(crc_q));
endmodule

// File: rtl/rxpk_hold.sv
module rxpk_hold #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dvalid
);
  logic [W-1:0]  stage [DEPTH];
  logic [FW-1:0] fill, fill_base;

  assign fill_base = clr ? '0 : fill;

  always_ff @(posedge clk) begin
    if (push) stage[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (push) stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill   <= '0;
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      dvalid <= 1'b0;
      fill   <= fill_base;
      if (push) begin
        if (fill_base == FW'(DEPTH)) begin
          dvalid <= 1'b1;
          dout   <= stage[DEPTH-1];
        end else begin
          fill <= fill_base + FW'(1);
        end
      end
    end
  end

  // R6
  hold_src_chk: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> $past(push));
  // R6
  hold_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH));
endmodule

// File: rtl/usb_rx_pkt_chk.sv
module usb_rx_pkt_chk
  import rxpk_pkg::*;
#(
  parameter int  MAX_BYTES = 1027,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              rx_active,
  input  logic              rx_error,
  output logic [BYTE_W-1:0] pl_data,
  output logic              pl_valid,
  output logic              done,
  output logic [3:0]        pkt_pid,
  output logic [CNT_W-1:0]  pkt_len,
  output logic              pid_ok,
  output logic              crc_ok,
  output logic              pkt_hshk,
  output logic              pkt_ack,
  output logic              pkt_short,
  output logic              pkt_bad
);
  localparam int OVERHEAD = 1 + CRC_BYTES;

  logic              act_q, err_q;
  logic [CNT_W-1:0]  cnt_q, cnt_base;
  logic [BYTE_W-1:0] pid_q;
  logic              start, fin, take, body;
  logic [CRC_W-1:0]  crc_q;

  assign start    = rx_active & ~act_q;
  assign fin      = act_q & ~rx_active;
  assign take     = rx_valid & rx_active;
  assign cnt_base = start ? '0 : cnt_q;
  assign body     = take && (cnt_base != '0);

  // packet bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      cnt_q <= '0;
      pid_q <= '0;
    end else begin
      act_q <= rx_active;
      if (start) begin
        cnt_q <= '0;
        pid_q <= '0;
        err_q <= 1'b0;
      end
      if (take) begin
        if (cnt_base != CNT_W'(MAX_BYTES)) cnt_q <= cnt_base + CNT_W'(1);
        if (cnt_base == '0) pid_q <= rx_data;
      end
      if (rx_active && rx_error) err_q <= 1'b1;
    end
  end

  rxpk_crc u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .en    (body),
    .din   (rx_data),
    .crc_q (crc_q)
  );

  rxpk_hold #(.W(BYTE_W), .DEPTH(CRC_BYTES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .push   (body && pid_is_data(pid_q[3:0])),
    .din    (rx_data),
    .dout   (pl_data),
    .dvalid (pl_valid)
  );

  // verdict, evaluated on the cycle the envelope closes
  logic v_pid, v_data, v_short, v_crc, v_hshk, v_ack;
  logic [CNT_W-1:0] v_len;

  always_comb begin
    v_pid   = (cnt_q != '0) && (pid_q[7:4] == ~pid_q[3:0]);
    v_data  = (cnt_q != '0) && pid_is_data(pid_q[3:0]);
    v_short = v_data && (cnt_q < CNT_W'(OVERHEAD));
    v_crc   = v_data && !v_short && (crc_q == CRC_GOOD);
    v_len   = (v_data && !v_short) ? cnt_q - CNT_W'(OVERHEAD) : '0;
    v_hshk  = (cnt_q == CNT_W'(1));
    v_ack   = v_hshk && (pid_q == ACK_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      pkt_pid   <= '0;
      pkt_len   <= '0;
      pid_ok    <= 1'b0;
      crc_ok    <= 1'b0;
      pkt_hshk  <= 1'b0;
      pkt_ack   <= 1'b0;
      pkt_short <= 1'b0;
      pkt_bad   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        pkt_pid   <= pid_q[3:0];
        pkt_len   <= v_len;
        pid_ok    <= v_pid;
        crc_ok    <= v_crc;
        pkt_hshk  <= v_hshk;
        pkt_ack   <= v_ack;
        pkt_short <= v_short;
        pkt_bad   <= err_q | ~v_pid | v_short | (v_data & ~v_crc);
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  done_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_active) |=> done);
  // R1
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_active || !rx_valid) && !start |=> $stable(cnt_q));
  // R9
  short_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pkt_short) |-> (pkt_len == '0) && !crc_ok && pkt_bad);
  // R7
  ack_class_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pkt_ack) |-> pkt_hshk && (pkt_pid == 4'h2));
  // R8
  err_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && err_q) |=> pkt_bad);
endmodule

// File: tb/usb_rx_pkt_chk_bench.sv
`timescale 1ns/1ps
module usb_rx_pkt_chk_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_active = 1'b0, rx_error = 1'b0;
  logic [7:0]  pl_data;
  logic        pl_valid, done;
  logic [3:0]  pkt_pid;
  logic [10:0] pkt_len;
  logic        pid_ok, crc_ok, pkt_hshk, pkt_ack, pkt_short, pkt_bad;

  always #2.5 clk = ~clk;

  usb_rx_pkt_chk u_usb_rx_pkt_chk (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_active(rx_active), .rx_error(rx_error), .pl_data(pl_data),
    .pl_valid(pl_valid), .done(done), .pkt_pid(pkt_pid), .pkt_len(pkt_len),
    .pid_ok(pid_ok), .crc_ok(crc_ok), .pkt_hshk(pkt_hshk), .pkt_ack(pkt_ack),
    .pkt_short(pkt_short), .pkt_bad(pkt_bad));

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_b [0:63];
  logic [7:0] got_pl [0:63];
  int got_n = 0, done_seen = 0, wd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (pl_valid) begin
        if (got_n < 64) got_pl[got_n] = pl_data;
        got_n++;
      end
      if (done) done_seen++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // reference CRC: MSB-first register on bit-reversed bytes, result reflected
  function automatic logic [15:0] ref_crc(input int first, input int cnt);
    logic [15:0] c, r;
    logic        top;
    c = 16'hFFFF;
    for (int k = 0; k < cnt; k++)
      for (int i = 0; i < 8; i++) begin
        top = c[15] ^ tx_b[first+k][i];
        c   = c << 1;
        if (top) c = c ^ 16'h8005;
      end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return r;
  endfunction

  task automatic build_data(input logic [7:0] pid, input int plen, input bit corrupt);
    logic [15:0] r;
    int pos;
    tx_b[0] = pid;
    for (int i = 1; i <= plen; i++) tx_b[i] = 8'($urandom);
    r = ref_crc(1, plen);
    tx_b[plen+1] = ~r[7:0];
    tx_b[plen+2] = ~r[15:8];
    if (corrupt) begin
      pos = $urandom_range(1, plen + 2);
      tx_b[pos] = tx_b[pos] ^ 8'($urandom_range(1, 255));
    end
  endtask

  task automatic send_pkt(input int n, input int err_at, input bit junk);
    got_n = 0; done_seen = 0;
    @(posedge clk); #1 rx_active = 1'b1; rx_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); #1 rx_valid = 1'b0; rx_error = 1'b0;
      end
      @(posedge clk); #1 rx_valid = 1'b1; rx_data = tx_b[i]; rx_error = (i == err_at);
    end
    @(posedge clk); #1 rx_valid = 1'b0; rx_error = 1'b0;
    @(posedge clk); #1 rx_active = 1'b0;
    if (junk) begin rx_valid = 1'b1; rx_data = 8'hA5; end
    @(posedge clk); #1 rx_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic check_pkt(input int n, input int err_at);
    bit e_pid, e_data, e_short, e_crc, e_hshk, e_ack, e_bad, pl_match;
    int e_len, e_pn;
    logic [15:0] r;
    logic [3:0] e_pidn;
    e_pidn  = (n >= 1) ? tx_b[0][3:0] : 4'h0;
    e_pid   = (n >= 1) && (tx_b[0][7:4] == ~tx_b[0][3:0]);
    e_data  = (n >= 1) && (tx_b[0][1:0] == 2'b11);
    e_short = e_data && (n < 3);
    e_crc   = 1'b0;
    if (e_data && n >= 3) begin
      r = ref_crc(1, n - 3);
      e_crc = ({~tx_b[n-1], ~tx_b[n-2]} == r);
    end
    e_len  = (e_data && n >= 3) ? n - 3 : 0;
    e_pn   = e_len;
    e_hshk = (n == 1);
    e_ack  = (n == 1) && (tx_b[0] == 8'hD2);
    e_bad  = (err_at >= 0 && err_at < n) || !e_pid || e_short || (e_data && !e_crc);
    chk(done_seen == 1, "R2", "done pulses", done_seen, 1);
    chk(pkt_pid == e_pidn, "R3", "pid", pkt_pid, e_pidn);
    chk(pid_ok == e_pid, "R3", "pid_ok", pid_ok, e_pid);
    chk(pkt_len == 11'(e_len), "R4", "len", pkt_len, e_len);
    chk(crc_ok == e_crc, e_data ? "R5" : "R11", "crc_ok", crc_ok, e_crc);
    chk(pkt_hshk == e_hshk, "R7", "hshk", pkt_hshk, e_hshk);
    chk(pkt_ack == e_ack, "R7", "ack", pkt_ack, e_ack);
    chk(pkt_short == e_short, "R9", "short", pkt_short, e_short);
    chk(pkt_bad == e_bad, (err_at >= 0) ? "R8" : "R12", "bad", pkt_bad, e_bad);
    chk(got_n == e_pn, e_data ? "R6" : "R11", "payload count", got_n, e_pn);
    pl_match = 1'b1;
    for (int i = 0; i < e_pn && i < got_n; i++)
      if (got_pl[i] !== tx_b[i+1]) pl_match = 1'b0;
    chk(pl_match, "R6", "payload bytes match", pl_match, 1);
  endtask

  task automatic run(input int n, input int err_at, input bit junk);
    send_pkt(n, err_at, junk);
    check_pkt(n, err_at);
  endtask

  logic [7:0] dpids [4] = '{8'hC3, 8'h4B, 8'h87, 8'h0F};
  logic [7:0] hpids [3] = '{8'hD2, 8'h5A, 8'h1E};
  logic [7:0] tpids [3] = '{8'hE1, 8'h69, 8'h2D};

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10
    chk(!done && !pl_valid && !pid_ok && !pkt_bad && pkt_len == 0, "R10",
        "reset outputs idle", {done, pl_valid, pid_ok, pkt_bad}, 0);

    // directed corners
    tx_b[0] = 8'hD2; run(1, -1, 0);                 // R7 acknowledge
    tx_b[0] = 8'h5A; run(1, -1, 0);                 // R7 other handshake
    run(0, -1, 0);                                  // R3 empty packet
    build_data(8'hC3, 0, 0); run(3, -1, 0);         // R4 zero payload
    build_data(8'h4B, 0, 0); run(2, -1, 0);         // R9 two bytes
    tx_b[0] = 8'hC3; run(1, -1, 0);                 // R9 lone data pid
    build_data(8'hC3, 6, 0); run(9, 4, 0);          // R8 error mid packet
    build_data(8'h4B, 5, 0); run(8, -1, 1);         // R1 junk at envelope fall
    build_data(8'h87, 7, 1); run(10, -1, 0);        // R5 corrupted byte
    tx_b[0] = 8'hE1; tx_b[1] = 8'h12; tx_b[2] = 8'h34; run(3, -1, 0); // R11
    tx_b[0] = 8'hC4; tx_b[1] = 8'h00; run(2, -1, 0);                  // R3 bad nibbles

    // constrained random
    for (int p = 0; p < 60; p++) begin
      int sel, n, plen, err_at;
      sel = $urandom_range(0, 9);
      err_at = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 4) : -1;
      if (sel <= 5 || sel == 9) begin
        plen = $urandom_range(0, 20);
        build_data(dpids[$urandom_range(0, 3)], plen, $urandom_range(0, 4) == 0);
        n = plen + 3;
        run(n, err_at, sel == 9);
      end else if (sel == 6) begin
        tx_b[0] = hpids[$urandom_range(0, 2)];
        run(1, err_at, 0);
      end else if (sel == 7) begin
        tx_b[0] = tpids[$urandom_range(0, 2)];
        tx_b[1] = 8'($urandom); tx_b[2] = 8'($urandom);
        run(3, err_at, 0);
      end else begin
        logic [3:0] lo;
        lo = 4'($urandom);
        tx_b[0] = {~lo ^ 4'($urandom_range(1, 15)), lo};
        n = $urandom_range(1, 10);
        for (int i = 1; i < n; i++) tx_b[i] = 8'($urandom);
        run(n, err_at, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule